// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Channel

This block is the receive half of a descriptor-ring DMA engine. A byte stream arrives one byte per cycle. Each byte can carry a start-of-frame marker and an end-of-frame marker. The bytes first enter a small internal FIFO. A writer state machine then fetches buffer descriptors from a ring by index and stores each frame into the posted buffers. A descriptor gives a buffer base address, a byte count and an end-of-ring flag. A frame that outgrows its first buffer continues at byte 0 of the next descriptor.

The first buffer of every frame reserves four bytes at its base for a status header. A programmable gap of zero to 127 bytes follows the header, and the payload starts after that gap. The engine writes the header only once the frame has ended. The header holds the payload length, the number of descriptors used and an overflow flag.

Software posts work by moving a last-descriptor index. The channel waits in idle when its current index reaches that value. A FIFO overflow either stops the channel with an error code or, when overflow-continue is set, truncates the frame and carries on. A status word reports the current index, the channel state and the error code.

Top module: `rxdma_ring_rx`

## Requirements
- R1: After reset, and after any cycle in which rx_ctrl[0] (enable) is low, rx_status reads 0: index 0 in bits 11:0, state 0 (disabled) in bits 15:12, error 0 in bits 19:16. No write and no descriptor request happens in the following cycle.
- R2: While enabled and without error, the state field reads 2 (idle wait) when the current index equals rx_last, and 1 (active) otherwise. A descriptor is requested only when the two differ, so a frame waits in the FIFO until rx_last moves.
- R3: In a frame's first buffer, payload byte k goes to base+4+offset+k, where offset is rx_ctrl[7:1]. After the end-of-frame byte, the engine writes a header at base+0..3: payload length low byte, length high byte, flags low byte, flags high byte (0). The length counts stored payload bytes only.
- R4: A buffer holds bytes up to its byte count, taken from desc_ctrl[12:0]. Further payload goes on at byte 0 of the next descriptor. Flags bits 3:0 give the number of descriptors used minus one.
- R5: The current index advances by one for each descriptor a frame consumes. After a descriptor with desc_ctrl[28] set, the index returns to 0.
- R6: With rx_ctrl[10] clear, a byte that arrives while the FIFO is full sets error 2 and state 3 (stopped). The channel stays stopped until enable is cleared.
- R7: With rx_ctrl[10] set, the engine drops the bytes of an overflowing frame from the first lost byte on. It finishes that frame with a header that has flags bit 7 set and the stored length, then handles later frames normally.
- R8: A first descriptor whose byte count is at most 4+offset, or a continuation descriptor with a byte count of 0, sets error 1 and stops the channel.
- R9: A descriptor response with desc_err set gives error 4. A write answered with wr_err gives error 3. Both stop the channel.
- R10: Bytes that arrive outside a frame, before any start-of-frame marker, are discarded and written nowhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ctrl | input | 32 | Control: bit 0 enable, bits 7:1 offset, bit 10 overflow-continue |
| rx_last | input | 12 | Index at which reception halts in idle wait |
| rx_status | output | 32 | Bits 11:0 index, 15:12 state, 19:16 error |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte starts a frame |
| in_eof | input | 1 | Byte ends a frame |
| in_data | input | 8 | Input byte |
| desc_req | output | 1 | Descriptor read request |
| desc_idx | output | 12 | Ring index of requested descriptor |
| desc_ack | input | 1 | Descriptor response valid |
| desc_err | input | 1 | Bus error on the descriptor response |
| desc_ctrl | input | 32 | Descriptor control: bits 12:0 byte count, bit 28 end of ring |
| desc_addr | input | ADDR_W | Descriptor buffer base address |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_addr | output | ADDR_W | Buffer byte address |
| wr_data | output | 8 | Buffer byte |
| wr_err | input | 1 | Bus error on the write presented this cycle |

## Verification
The bench goes after the spill points. These are a frame that exactly fills its first buffer, a frame that spills by one byte, and the largest offset. A design that gets the spill test wrong fetches a spare descriptor or writes past the buffer, so the index and the flags count come out off by one. The bench holds a frame while rx_last equals the index, then checks it against the end-of-ring wrap. A broken idle compare writes the frame too early, and a broken wrap writes into an unposted descriptor. The overflow tests fill the FIFO while no descriptor is posted. A design that loses the end marker hangs without a header. A design that ignores the mode bit stops where it should continue, or continues where it should stop.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int IDX_W = 12;
  localparam int CNT_W = 13;
  localparam int HDR_BYTES = 4;

  typedef struct packed {
    logic       tok;   // overflow end token, carries no data
    logic       eof;
    logic       sof;
    logic [7:0] data;
  } rx_ent_t;

  typedef enum logic [2:0] {
    W_DIS, W_WAIT, W_FETCH, W_DATA, W_HDR, W_STOP
  } wr_st_e;

  localparam logic [3:0] ST_OFF  = 4'd0;
  localparam logic [3:0] ST_RUN  = 4'd1;
  localparam logic [3:0] ST_IDLE = 4'd2;
  localparam logic [3:0] ST_HALT = 4'd3;

  localparam logic [3:0] E_NONE  = 4'd0;
  localparam logic [3:0] E_PROTO = 4'd1;
  localparam logic [3:0] E_OVF   = 4'd2;
  localparam logic [3:0] E_WBUS  = 4'd3;
  localparam logic [3:0] E_DBUS  = 4'd4;
endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign dout  = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
endmodule

// File: rtl/rxdma_ingress.sv
module rxdma_ingress
  import rxdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       ovf_cont,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  input  logic       full,
  output logic       push,
  output rx_ent_t    push_ent,
  output logic       ovf_evt
);
  logic drop, pend, drop_n, pend_n;

  always_comb begin
    push     = 1'b0;
    push_ent = '0;
    ovf_evt  = 1'b0;
    drop_n   = drop;
    pend_n   = pend;
    if (!flush) begin
      if (pend) begin
        if (!full) begin
          push = 1'b1; push_ent.tok = 1'b1; pend_n = 1'b0; drop_n = 1'b0;
        end
      end else if (in_valid) begin
        if (drop) begin
          if (in_eof) begin
            if (!full) begin
              push = 1'b1; push_ent.tok = 1'b1; drop_n = 1'b0;
            end else begin
              pend_n = 1'b1;
            end
          end
        end else if (full) begin
          if (ovf_cont) begin
            drop_n = 1'b1;
            pend_n = in_eof;
          end else begin
            ovf_evt = 1'b1;
          end
        end else begin
          push     = 1'b1;
          push_ent = '{tok: 1'b0, eof: in_eof, sof: in_sof, data: in_data};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      drop <= 1'b0;
      pend <= 1'b0;
    end else begin
      drop <= drop_n;
      pend <= pend_n;
    end
  end
endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [6:0]        offset,
  input  logic [IDX_W-1:0]  last_idx,
  input  rx_ent_t           head,
  input  logic              empty,
  output logic              pop,
  input  logic              ovf_evt,
  output logic              desc_req,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic              desc_ack,
  input  logic              desc_err,
  input  logic [CNT_W-1:0]  desc_count,
  input  logic              desc_eot,
  input  logic [ADDR_W-1:0] desc_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_err,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [3:0]        err,
  output logic              stopped
);
  wr_st_e            st;
  logic              first, eot_r, ovf_flag;
  logic [ADDR_W-1:0] base, first_base;
  logic [CNT_W-1:0]  cnt, pos, min_cnt;
  logic [15:0]       len;
  logic [3:0]        ndesc;
  logic [1:0]        hdr_i;
  logic [7:0]        hdr_byte;
  logic [IDX_W-1:0]  nxt_idx;

  assign min_cnt  = first ? (CNT_W'(HDR_BYTES) + CNT_W'(offset)) : '0;
  assign nxt_idx  = eot_r ? '0 : cur_idx + 1'b1;
  assign desc_req = enable && (st == W_FETCH) && (cur_idx != last_idx);
  assign desc_idx = cur_idx;
  assign stopped  = (st == W_STOP);

  always_comb begin
    case (hdr_i)
      2'd0:    hdr_byte = len[7:0];
      2'd1:    hdr_byte = len[15:8];
      2'd2:    hdr_byte = {ovf_flag, 3'b000, ndesc};
      default: hdr_byte = 8'h00;
    endcase
  end

  always_comb begin
    pop = 1'b0;
    if (enable && !empty) begin
      if (st == W_WAIT) pop = head.tok || !head.sof;
      else if (st == W_DATA) pop = head.tok || (pos != cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_DIS; cur_idx <= '0; err <= E_NONE; wr_en <= 1'b0;
      wr_addr <= '0; wr_data <= '0; first <= 1'b0; eot_r <= 1'b0;
      ovf_flag <= 1'b0; base <= '0; first_base <= '0; cnt <= '0;
      pos <= '0; len <= '0; ndesc <= '0; hdr_i <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!enable) begin
        st <= W_DIS; cur_idx <= '0; err <= E_NONE;
      end else if (wr_en && wr_err && st != W_STOP) begin
        err <= E_WBUS; st <= W_STOP;
      end else if (ovf_evt && st != W_STOP) begin
        err <= E_OVF; st <= W_STOP;
      end else begin
        case (st)
          W_DIS: st <= W_WAIT;
          W_WAIT: begin
            if (!empty && !head.tok && head.sof && cur_idx != last_idx) begin
              st <= W_FETCH; first <= 1'b1; len <= '0;
              ovf_flag <= 1'b0; ndesc <= '0;
            end
          end
          W_FETCH: begin
            if (desc_req && desc_ack) begin
              if (desc_err) begin
                err <= E_DBUS; st <= W_STOP;
              end else if (desc_count <= min_cnt) begin
                err <= E_PROTO; st <= W_STOP;
              end else begin
                base <= desc_addr; cnt <= desc_count; pos <= min_cnt;
                eot_r <= desc_eot; st <= W_DATA;
                if (first) first_base <= desc_addr;
                else if (ndesc != 4'hF) ndesc <= ndesc + 1'b1;
              end
            end
          end
          W_DATA: begin
            if (!empty) begin
              if (head.tok) begin
                ovf_flag <= 1'b1; st <= W_HDR; hdr_i <= '0;
              end else if (pos == cnt) begin
                cur_idx <= nxt_idx; first <= 1'b0; st <= W_FETCH;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= base + ADDR_W'(pos);
                wr_data <= head.data;
                pos     <= pos + 1'b1;
                len     <= len + 1'b1;
                if (head.eof) begin
                  st <= W_HDR; hdr_i <= '0;
                end
              end
            end
          end
          W_HDR: begin
            wr_en   <= 1'b1;
            wr_addr <= first_base + ADDR_W'(hdr_i);
            wr_data <= hdr_byte;
            hdr_i   <= hdr_i + 1'b1;
            if (hdr_i == 2'd3) begin
              cur_idx <= nxt_idx; st <= W_WAIT;
            end
          end
          default: st <= W_STOP;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxdma_ring_rx.sv
module rxdma_ring_rx
  import rxdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       rx_ctrl,
  input  logic [11:0]       rx_last,
  output logic [31:0]       rx_status,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  output logic              desc_req,
  output logic [11:0]       desc_idx,
  input  logic              desc_ack,
  input  logic              desc_err,
  input  logic [31:0]       desc_ctrl,
  input  logic [ADDR_W-1:0] desc_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_err
);
  localparam int ENT_W = $bits(rx_ent_t);

  logic       enable, ovf_cont, flush, push, pop, empty, full, ovf_evt, stopped;
  logic [6:0] offset;
  rx_ent_t    push_ent, head;
  logic [ENT_W-1:0] head_raw;
  logic [IDX_W-1:0] cur_idx;
  logic [3:0] err, state;
  logic       unused_bits;

  assign enable   = rx_ctrl[0];
  assign offset   = rx_ctrl[7:1];
  assign ovf_cont = rx_ctrl[10];
  assign flush    = !enable || stopped;
  assign head     = rx_ent_t'(head_raw);
  assign unused_bits = ^{rx_ctrl[31:11], rx_ctrl[9:8], desc_ctrl[31:29], desc_ctrl[27:13]};

  rxdma_ingress u_ing (
    .clk(clk), .rst(rst), .flush(flush), .ovf_cont(ovf_cont),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .full(full), .push(push), .push_ent(push_ent), .ovf_evt(ovf_evt)
  );

  rxdma_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .din(push_ent),
    .pop(pop), .dout(head_raw), .empty(empty), .full(full)
  );

  rxdma_writer #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .enable(enable), .offset(offset), .last_idx(rx_last),
    .head(head), .empty(empty), .pop(pop), .ovf_evt(ovf_evt),
    .desc_req(desc_req), .desc_idx(desc_idx), .desc_ack(desc_ack),
    .desc_err(desc_err), .desc_count(desc_ctrl[CNT_W-1:0]),
    .desc_eot(desc_ctrl[28]), .desc_addr(desc_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .cur_idx(cur_idx), .err(err), .stopped(stopped)
  );

  always_comb begin
    if (!enable)               state = ST_OFF;
    else if (err != E_NONE)    state = ST_HALT;
    else if (cur_idx == rx_last) state = ST_IDLE;
    else                       state = ST_RUN;
  end

  assign rx_status = {12'h000, err, state, cur_idx};
endmodule

// File: rtl/rxdma_ring_rx_chk.sv
module rxdma_ring_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] state,
  input logic       desc_req,
  input logic       wr_en
);
  // R1: a cycle with enable low is followed by no traffic
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!wr_en && !desc_req));

  // R2: descriptor requests are issued only in the active state
  a_r2_fetch_only_active: assert property (@(posedge clk) disable iff (rst)
    desc_req |-> (state == 4'd1));

  // R3: buffer writes and descriptor fetches never overlap
  a_r3_write_excl_fetch: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !desc_req);

  // R6: the stopped state holds while enable stays high
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    (en && state == 4'd3) |=> (!en || state == 4'd3));
endmodule

bind rxdma_ring_rx rxdma_ring_rx_chk u_chk (
  .clk(clk), .rst(rst), .en(rx_ctrl[0]), .state(rx_status[15:12]),
  .desc_req(desc_req), .wr_en(wr_en)
);

// File: tb/rxdma_ring_rx_tb.sv
`timescale 1ns/1ps
module rxdma_ring_rx_tb;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] rx_ctrl = '0;
  logic [11:0] rx_last = '0;
  logic [31:0] rx_status;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = '0;
  logic desc_req, desc_ack = 0, desc_err = 0, wr_en, wr_err = 0;
  logic [11:0] desc_idx;
  logic [31:0] desc_ctrl = '0;
  logic [ADDR_W-1:0] desc_addr = '0, wr_addr;
  logic [7:0] wr_data;

  logic [7:0]  mem [0:4095];
  logic [31:0] d_ctrl [0:15];
  logic [15:0] d_addr [0:15];
  logic d_berr = 0;
  int   w_berr_addr = -1;
  int   tests = 0, fails = 0;

  // offset, payload length, buffer byte count
  localparam int VEC [6][3] = '{'{0,5,32}, '{3,10,32}, '{0,28,32},
                                '{0,29,32}, '{5,40,16}, '{127,3,140}};

  rxdma_ring_rx #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .rx_ctrl(rx_ctrl), .rx_last(rx_last), .rx_status(rx_status),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .desc_req(desc_req), .desc_idx(desc_idx), .desc_ack(desc_ack), .desc_err(desc_err),
    .desc_ctrl(desc_ctrl), .desc_addr(desc_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (desc_req && !desc_ack) begin
      desc_ack = 1; desc_ctrl = d_ctrl[desc_idx[3:0]];
      desc_addr = d_addr[desc_idx[3:0]]; desc_err = d_berr;
    end else begin
      desc_ack = 0; desc_err = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    wr_err = wr_en && (int'(wr_addr) == w_berr_addr);
    if (wr_en) mem[wr_addr[11:0]] = wr_data;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int n, int seed);
    for (int k = 0; k < n; k++) begin
      in_valid = 1; in_sof = (k == 0); in_eof = (k == n - 1);
      in_data = 8'((seed + k) & 255);
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic ring(int c, int eot_at);
    for (int i = 0; i < 16; i++) begin
      d_ctrl[i] = 32'(c) | ((i == eot_at) ? 32'h1000_0000 : 32'h0);
      d_addr[i] = 16'(i * 256);
    end
  endtask

  task automatic restart(logic [31:0] ctrl, int last);
    rx_ctrl = '0;
    tick(2);
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rx_last = 12'(last);
    rx_ctrl = ctrl;
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(2);
    chk("R1 reset status", int'(rx_status), 0);

    // vector table: layout, spill, offsets
    for (int r = 0; r < 6; r++) begin
      int off, len, c, d, p, bad, seed;
      off = VEC[r][0]; len = VEC[r][1]; c = VEC[r][2]; seed = r * 40 + 1;
      ring(c, 99);
      restart(32'((off << 1) | 1), 12);
      send(len, seed);
      tick(len + 60);
      d = 0; p = 4 + off; bad = 0;
      for (int k = 0; k < len; k++) begin
        if (p == c) begin d++; p = 0; end
        if (int'(mem[d * 256 + p]) != ((seed + k) & 255)) bad++;
        p++;
      end
      chk("R3 payload placement", bad, 0);
      chk("R3 header length", int'(mem[0]) | (int'(mem[1]) << 8), len);
      chk("R4 descriptors used minus one", int'(mem[2]), d);
      chk("R3 flags high byte", int'(mem[3]), 0);
      chk("R5 index after frame", int'(rx_status[11:0]), d + 1);
    end

    // R2: frame held while index equals rx_last
    ring(32, 99);
    restart(32'h1, 0);
    chk("R2 idle state", int'(rx_status[15:12]), 2);
    send(6, 8'h50);
    tick(30);
    chk("R2 no write while idle", int'(mem[4]), 0);
    rx_last = 12'd3;
    tick(30);
    chk("R2 frame after post", int'(mem[4]), 8'h50);
    chk("R2 active state", int'(rx_status[15:12]), 1);

    // R5: wrap after end-of-ring descriptor
    ring(32, 1);
    restart(32'h1, 5);
    send(4, 8'h11); tick(20);
    send(4, 8'h22); tick(20);
    chk("R5 wrap to zero", int'(rx_status[11:0]), 0);
    send(4, 8'h33); tick(20);
    chk("R5 reuse descriptor 0", int'(mem[4]), 8'h33);

    // R10: stray bytes before start marker
    ring(32, 99);
    restart(32'h1, 5);
    in_valid = 1; in_data = 8'hEE; tick(3); in_valid = 0;
    send(5, 8'h60); tick(30);
    chk("R10 length ignores stray", int'(mem[0]), 5);
    chk("R10 first payload byte", int'(mem[4]), 8'h60);

    // R6: overflow without continue
    restart(32'h1, 0);
    send(20, 8'h10); tick(5);
    chk("R6 error code", int'(rx_status[19:16]), 2);
    chk("R6 stopped", int'(rx_status[15:12]), 3);
    rx_last = 12'd5; tick(20);
    chk("R6 sticky", int'(rx_status[15:12]), 3);
    rx_ctrl = '0; tick(2);
    chk("R1 disable clears", int'(rx_status), 0);

    // R7: overflow continue
    restart(32'h401, 0);
    send(20, 8'h20); tick(5);
    chk("R7 no error", int'(rx_status[19:16]), 0);
    rx_last = 12'd5; tick(40);
    chk("R7 truncated length", int'(mem[0]), 16);
    chk("R7 overflow flag", int'(mem[2]), 8'h80);
    chk("R7 last stored byte", int'(mem[19]), 8'h2F);
    send(5, 8'h70); tick(30);
    chk("R7 next frame length", int'(mem[256]), 5);
    chk("R7 next frame flags", int'(mem[258]), 0);
    chk("R7 next frame data", int'(mem[260]), 8'h70);

    // R8: descriptor too small
    ring(4, 99);
    restart(32'h1, 5);
    send(3, 8'h01); tick(20);
    chk("R8 protocol error", int'(rx_status[19:16]), 1);

    // R9: descriptor bus error, then write bus error
    ring(32, 99);
    d_berr = 1;
    restart(32'h1, 5);
    send(3, 8'h01); tick(20);
    chk("R9 descriptor bus error", int'(rx_status[19:16]), 4);
    d_berr = 0;
    w_berr_addr = 6;
    restart(32'h1, 5);
    send(5, 8'h01); tick(20);
    chk("R9 write bus error", int'(rx_status[19:16]), 3);
    chk("R9 stopped", int'(rx_status[15:12]), 3);
    w_berr_addr = -1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule